// File: doc/BRIEF.md
# Modulo-3 Transition-Signaling Event Counter

This block counts events that arrive as level changes on a single input wire and answers each one with a level change on one of two output wires. In every group of three input events, the first two are answered on the "minor" output and the third on the "major" output. The pattern then starts over and repeats for as long as events keep arriving. A rising edge and a falling edge on the input are both one event, and each answer is one flip of an output level. No return-to-zero phase is used on any wire.

The block models a clockless handshake element inside a synchronous design. The input is sampled on every clock edge, and a change against the previously sampled level is one event. The answer appears one clock later. The sender is expected to wait for that answer before it changes the input again. If the input changes while an answer is still pending, the block raises a sticky protocol-error flag and discards that change.

The number of events per cycle is a parameter, with a default of three. The last event of each cycle goes to the major output.

Top module: `modTriCounter`

## Requirements
- R1: While `rstN` is low, and on the first edge after it is released, `outQ`, `outP` and `protoErr` are all 0.
- R2: A change of `evIn` that is first sampled at clock edge k causes exactly one output flip at edge k+1. The outputs do not change at edge k.
- R3: Within each group of three accepted events, events 1 and 2 flip `outQ` and event 3 flips `outP`.
- R4: The pattern repeats without limit. Event 4 flips `outQ` again, and events 3, 6, 9 and so on flip `outP`.
- R5: A rising change and a falling change of `evIn` each count as one event, with identical effect.
- R6: A change of `evIn` sampled at the edge where an answer is still pending sets `protoErr`. It produces no extra output flip and does not advance the pattern.
- R7: `protoErr` stays 1 until the next reset, and reset clears it.
- R8: At reset, the current level of `evIn` becomes the reference level. Holding `evIn` high through reset produces no event.
- R9: At most one of `outQ` and `outP` flips per cycle. Neither flips without a preceding accepted event, so the outputs hold steady while `evIn` is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Synchronous active-low reset |
| evIn | input | 1 | Input event wire; each level change is one event |
| outQ | output | 1 | Minor answer wire; flips for events 1 and 2 of each group |
| outP | output | 1 | Major answer wire; flips for the last event of each group |
| protoErr | output | 1 | Sticky flag for an input change that arrived before the answer |

## Verification
The bench times the answer to each event edge by edge. A design that answered in the same cycle, or two cycles late, fails the check before the flip or the check after it. It sweeps runs of events over several idle gaps, past the third and sixth events. This catches a phase counter that wraps at the wrong value or that gives the major answer to the wrong event of the group. It also covers falling edges and a reset taken with the input held high. A block that detected only rising edges, or that did not latch the input level as its reference at reset, would miss events or invent one. Finally, it drives an input change one cycle too early and checks that the flag is set and stays set. The answer count and the pattern position must be unchanged, which exposes a design that counts the early change or lets the flag clear.

// File: rtl/modTriPkg.sv
package modTriPkg;

  // Strobes from the control FSM to the datapath registers.
  typedef struct packed {
    logic fireQ;    // flip the minor answer wire
    logic fireP;    // flip the major answer wire
    logic flagErr;  // input changed while an answer was pending
  } ctrlStrobeT;

endpackage

// File: rtl/modTriDatapath.sv
module modTriDatapath
  import modTriPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evIn,
  input  ctrlStrobeT strobes,
  output logic       toggleSeen,
  output logic       outQ,
  output logic       outP,
  output logic       protoErr
);

  logic lastLevel;
  logic qLevel;
  logic pLevel;
  logic errLatch;

  // An event is any difference from the level held at the previous edge.
  always_comb toggleSeen = evIn ^ lastLevel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastLevel <= evIn;      // reference level taken during reset
      qLevel    <= 1'b0;
      pLevel    <= 1'b0;
      errLatch  <= 1'b0;
    end else begin
      lastLevel <= evIn;      // a discarded early change is still absorbed
      qLevel    <= qLevel ^ strobes.fireQ;
      pLevel    <= pLevel ^ strobes.fireP;
      errLatch  <= errLatch | strobes.flagErr;
    end
  end

  assign outQ     = qLevel;
  assign outP     = pLevel;
  assign protoErr = errLatch;

endmodule

// File: rtl/modTriControl.sv
module modTriControl
  import modTriPkg::*;
#(
  parameter int MOD_COUNT = 3,
  localparam int PHASE_W  = $clog2(MOD_COUNT)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       toggleSeen,
  output ctrlStrobeT strobes,
  output logic       pending
);

  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(MOD_COUNT - 1);
  localparam logic [PHASE_W-1:0] STEP       = PHASE_W'(1);

  logic [PHASE_W-1:0] phase;
  logic               pendingReg;
  logic               lastHit;

  always_comb begin
    lastHit         = (phase == LAST_PHASE);
    strobes.fireQ   = pendingReg & ~lastHit;
    strobes.fireP   = pendingReg & lastHit;
    strobes.flagErr = pendingReg & toggleSeen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= '0;
      pendingReg <= 1'b0;
    end else if (pendingReg) begin
      // Answer goes out this edge; any new change is discarded as an error.
      pendingReg <= 1'b0;
      phase      <= lastHit ? '0 : phase + STEP;
    end else if (toggleSeen) begin
      pendingReg <= 1'b1;
    end
  end

  assign pending = pendingReg;

endmodule

// File: rtl/modTriCounter.sv
module modTriCounter
  import modTriPkg::*;
#(
  parameter int MOD_COUNT = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic evIn,
  output logic outQ,
  output logic outP,
  output logic protoErr
);

  ctrlStrobeT strobes;
  logic       toggleSeen;
  logic       pending;

  modTriControl #(.MOD_COUNT(MOD_COUNT)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .toggleSeen(toggleSeen),
    .strobes   (strobes),
    .pending   (pending)
  );

  modTriDatapath u_data (
    .clk       (clk),
    .rstN      (rstN),
    .evIn      (evIn),
    .strobes   (strobes),
    .toggleSeen(toggleSeen),
    .outQ      (outQ),
    .outP      (outP),
    .protoErr  (protoErr)
  );

endmodule

// File: rtl/modTriChecker.sv
module modTriChecker (
  input logic clk,
  input logic rstN,
  input logic outQ,
  input logic outP,
  input logic protoErr,
  input logic pending
);

  // R9: never both answer wires in one cycle
  assert_single_answer_R9: assert property (@(posedge clk) disable iff (!rstN)
    !((outQ != $past(outQ)) && (outP != $past(outP))));

  // R9: an answer flip is always preceded by a pending event
  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((outQ != $past(outQ)) || (outP != $past(outP))) |-> $past(pending));

  // R2: a pending event is answered on the very next edge
  assert_reply_next_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending) |=> ((outQ != $past(outQ)) || (outP != $past(outP))));

  // R2: pending lasts a single cycle
  assert_pending_once_R2: assert property (@(posedge clk) disable iff (!rstN)
    pending |=> !pending);

  // R7: the error flag never clears outside reset
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

  // R6: the error flag only rises out of a pending answer
  assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protoErr) |-> $past(pending));

endmodule

bind modTriCounter modTriChecker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .outQ    (outQ),
  .outP    (outP),
  .protoErr(protoErr),
  .pending (pending)
);

// File: tb/sim_modTriCounter.sv
module sim_modTriCounter;

  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rstN;
  logic evIn;
  logic outQ, outP, protoErr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model
  int  phaseM = 0;
  logic expQ = 1'b0, expP = 1'b0, expErr = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  modTriCounter u0 (
    .clk(clk), .rstN(rstN), .evIn(evIn),
    .outQ(outQ), .outP(outP), .protoErr(protoErr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelEvent();
    if (phaseM == 2) expP = ~expP; else expQ = ~expQ;
    phaseM = (phaseM + 1) % 3;
  endtask

  task automatic chkAll(input string req);
    chk(outQ == expQ, {req, " outQ"}, outQ, expQ);
    chk(outP == expP, {req, " outP"}, outP, expP);
    chk(protoErr == expErr, {req, " protoErr"}, protoErr, expErr);
  endtask

  // Toggle at a negedge; check nothing moves at edge k, answer at edge k+1.
  task automatic timedEvent();
    logic oldQ, oldP;
    string tag;
    oldQ = expQ; oldP = expP;
    tag = evIn ? "R5 falling" : "R3 rising";
    evIn = ~evIn;
    @(negedge clk);
    chk(outQ == oldQ && outP == oldP, {"R2 no early answer ", tag},
        {outQ, outP}, {oldQ, oldP});
    modelEvent();
    @(negedge clk);
    chk(outQ == expQ && outP == expP, {"R2 answer next edge ", tag},
        {outQ, outP}, {expQ, expP});
  endtask

  initial begin
    evIn = 1'b0;
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    chkAll("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    chkAll("R1 after release");

    // edge-accurate timing over three full groups, both edge directions
    for (int i = 0; i < 9; i++) timedEvent();
    chkAll("R4 after nine events");

    // sweep of gaps and run lengths
    for (int g = 2; g <= 6; g++) begin
      for (int n = 1; n <= 7; n++) begin
        evIn = ~evIn;
        modelEvent();
        repeat (g) @(negedge clk);
      end
      chkAll("R3 R4 gap sweep");
    end

    // idle: nothing may move
    repeat (12) @(negedge clk);
    chkAll("R9 idle stable");

    // early change while answer pending
    evIn = ~evIn;
    modelEvent();
    @(negedge clk);
    evIn = ~evIn;
    expErr = 1'b1;
    repeat (3) @(negedge clk);
    chkAll("R6 early change discarded");
    evIn = ~evIn;
    modelEvent();
    repeat (3) @(negedge clk);
    chkAll("R6 pattern not advanced");
    for (int i = 0; i < 4; i++) begin
      evIn = ~evIn;
      modelEvent();
      repeat (3) @(negedge clk);
    end
    chkAll("R7 flag held");

    // reset with input high
    rstN = 1'b0;
    evIn = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    phaseM = 0; expQ = 1'b0; expP = 1'b0; expErr = 1'b0;
    repeat (4) @(negedge clk);
    chkAll("R8 R7 high level at reset");
    evIn = 1'b0;
    modelEvent();
    repeat (3) @(negedge clk);
    chkAll("R5 falling first event");
    for (int i = 0; i < 2; i++) begin
      evIn = ~evIn;
      modelEvent();
      repeat (2) @(negedge clk);
    end
    chkAll("R3 third event major");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule